// File: doc/BRIEF.md
# Framebuffer pixel unpacker

This block sits between a framebuffer read stream and a display pipeline. Each accepted 32-bit word is split into pixels, one pixel per cycle, on a valid/ready output. At depths of 8 bits per pixel or fewer, each output value is a palette index that a later stage looks up. At 16 and 32 bits per pixel, the value is the direct colour. Two independent controls choose big-endian ordering. One reverses the bytes of each word. The other, used only while the byte control is clear, takes sub-byte pixels from the high end of each byte first.

From the depth mode and the panel width, the block also derives the number of framebuffer bytes that one panel row occupies. An address generator uses this value as its row stride. The block unpacks only while the controller is both enabled and powered. Reads from memory, palette lookup and panel timing are handled outside the block.

Top module: `pix_unpack`

## Requirements
- R1: `depth_mode` selects 1, 2, 4, 8, 16 or 32 bits per pixel for codes 0, 1, 2, 3, 4 and 5. One accepted word yields exactly 32, 16, 8, 4, 2 or 1 pixels.
- R2: With both ordering controls clear, pixel k of a word is bits [k*bpp +: bpp]. Pixels therefore start at the least significant end.
- R3: With `swap_bytes` set, the word's bytes are reversed (byte 3 becomes byte 0) and the result is unpacked as in R2. `swap_pixels` has no effect while `swap_bytes` is set.
- R4: With `swap_pixels` set and `swap_bytes` clear, bytes are still taken lowest first. Within each byte, sub-byte pixels are taken from the most significant bits first. At 8, 16 and 32 bpp the output is the same as in R2.
- R5: `row_bytes` is the width shifted right by 3, 2 or 1 at 1, 2 or 4 bpp. It equals the width at 8 bpp, width*2 at 16 bpp, width*4 at 32 bpp, and 0 for codes 6 and 7.
- R6: `in_ready` is high only when no pixel of the previous word is still pending.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pixel` holds its value, so no pixel is lost.
- R8: While `ctl_enable` or `ctl_power` is low, `in_ready` and `out_valid` are low. Pending pixels resume in order once both are high again.
- R9: Codes 6 and 7 are reserved. In these modes, words are accepted and discarded, and no pixel is emitted.
- R10: `out_direct` is 1 at 16 and 32 bpp and 0 otherwise. Bits of `out_pixel` above the pixel width are zero.
- R11: After reset, no pixel is pending: `out_valid` is low and `in_ready` is high once the block is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable |
| ctl_power | input | 1 | Panel power on |
| depth_mode | input | 3 | Depth code, see R1 |
| swap_bytes | input | 1 | Big-endian byte order within the word |
| swap_pixels | input | 1 | Big-endian pixel order within the byte |
| panel_width | input | WIDTH_W | Panel width in pixels |
| row_bytes | output | WIDTH_W+2 | Source bytes per panel row |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Downstream can take the pixel |
| out_pixel | output | 32 | Palette index or direct colour, zero-extended |
| out_direct | output | 1 | 1 when out_pixel is direct colour |

## Verification
The bench runs every valid depth against all four combinations of the ordering controls, using words whose fields differ at every bit position. A reversed byte walk or a wrong in-byte offset would therefore show up as a wrong pixel value. It also checks that setting both controls gives the byte-swap result, so a design that applied the pixel swap on top would fail. Stalls on the output test for dropped or repeated pixels, and a design that counted pixels per word wrongly would either raise `in_ready` early or leave the last pixels pending. Further checks cover the row-byte sweep at width edges (values that are not multiples of 8, and the widest width), loss of power or enable in the middle of a word, and discarding of words in the reserved modes.

// File: rtl/pu_pkg.sv
package pu_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTES   = WORD_W / 8;
    localparam int IDX_W   = 6;

    typedef enum logic [2:0] {
        DEPTH_1    = 3'd0,
        DEPTH_2    = 3'd1,
        DEPTH_4    = 3'd2,
        DEPTH_8    = 3'd3,
        DEPTH_16   = 3'd4,
        DEPTH_32   = 3'd5,
        DEPTH_RSV6 = 3'd6,
        DEPTH_RSV7 = 3'd7
    } depth_e;

    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  idx;
    } wbuf_t;

    function automatic logic depth_ok(depth_e m);
        return (m != DEPTH_RSV6) && (m != DEPTH_RSV7);
    endfunction

    // number of pixels carried by one word; zero for reserved codes
    function automatic logic [IDX_W-1:0] pix_per_word(depth_e m);
        if (!depth_ok(m)) return '0;
        return 6'd32 >> m;
    endfunction

endpackage

// File: rtl/pu_stride.sv
module pu_stride
    import pu_pkg::*;
#(
    parameter int WIDTH_W = 12
) (
    input  depth_e               mode,
    input  logic [WIDTH_W-1:0]   width,
    output logic [WIDTH_W+1:0]   bytes
);
    localparam int BW = WIDTH_W + 2;

    logic [BW-1:0] wide;

    always_comb begin
        wide = BW'(width);
        unique case (mode)
            DEPTH_1:  bytes = wide >> 3;
            DEPTH_2:  bytes = wide >> 2;
            DEPTH_4:  bytes = wide >> 1;
            DEPTH_8:  bytes = wide;
            DEPTH_16: bytes = wide << 1;
            DEPTH_32: bytes = wide << 2;
            default:  bytes = '0;
        endcase
    end

endmodule

// File: rtl/pu_extract.sv
module pu_extract
    import pu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  depth_e            mode,
    input  logic              swap_bytes,
    input  logic              swap_pixels,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] pixel
);
    logic [WORD_W-1:0] rev;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] mask;
    logic [2:0]        lg;
    logic [2:0]        sh;
    logic [7:0]        idx8;
    logic [7:0]        bpp8;
    logic [7:0]        byte8;
    logic [7:0]        pos8;
    logic [7:0]        off8;

    for (genvar b = 0; b < BYTES; b++) begin : g_rev
        assign rev[8*b +: 8] = word[8*(BYTES-1-b) +: 8];
    end

    always_comb begin
        src   = swap_bytes ? rev : word;
        lg    = mode;
        idx8  = {2'b00, idx};
        bpp8  = 8'd1 << lg;
        sh    = 3'd0;
        byte8 = '0;
        pos8  = '0;
        if (lg < 3'd3) begin
            sh    = 3'd3 - lg;
            byte8 = idx8 >> sh;
            pos8  = (idx8 & ((8'd1 << sh) - 8'd1)) << lg;
            // in-byte order flips only when byte order is little-endian
            if (swap_pixels && !swap_bytes) begin
                pos8 = 8'd8 - bpp8 - pos8;
            end
            off8 = (byte8 << 3) + pos8;
        end else begin
            off8 = idx8 << lg;
        end
        if (lg >= 3'd5) begin
            mask = '1;
        end else begin
            mask = (32'd1 << bpp8) - 32'd1;
        end
        pixel = (src >> off8[4:0]) & mask;
    end

endmodule

// File: rtl/pu_word_buf.sv
module pu_word_buf
    import pu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              mode_ok,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              buf_valid,
    input  logic              buf_take,
    output logic [WORD_W-1:0] buf_word,
    output logic [IDX_W-1:0]  buf_idx
);
    wbuf_t st_d, st_q;
    logic  in_fire;
    logic  pix_fire;

    always_comb begin
        st_d      = st_q;
        in_ready  = active && !st_q.full;
        in_fire   = in_valid && in_ready;
        buf_valid = active && st_q.full && mode_ok;
        pix_fire  = buf_valid && buf_take;

        if (pix_fire) begin
            if (st_q.idx == last_idx) begin
                st_d.full = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
        // a word held across a change to a reserved code is discarded
        if (active && st_q.full && !mode_ok) begin
            st_d.full = 1'b0;
        end
        if (in_fire) begin
            st_d.word = in_word;
            st_d.idx  = '0;
            st_d.full = mode_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_word = st_q.word;
    assign buf_idx  = st_q.idx;

    assert_reserved_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !mode_ok) |=> !st_q.full);

    assert_idx_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && mode_ok) |-> (st_q.idx <= last_idx));

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pu_pkg::*;
#(
    parameter int WIDTH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_enable,
    input  logic               ctl_power,
    input  logic [2:0]         depth_mode,
    input  logic               swap_bytes,
    input  logic               swap_pixels,
    input  logic [WIDTH_W-1:0] panel_width,
    output logic [WIDTH_W+1:0] row_bytes,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_word,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [31:0]        out_pixel,
    output logic               out_direct
);
    depth_e             mode;
    logic               active;
    logic               mode_ok;
    logic [IDX_W-1:0]   last_idx;
    logic [WORD_W-1:0]  cur_word;
    logic [IDX_W-1:0]   cur_idx;

    always_comb begin
        mode       = depth_e'(depth_mode);
        active     = ctl_enable && ctl_power;
        mode_ok    = depth_ok(mode);
        last_idx   = pix_per_word(mode) - 1'b1;
        out_direct = (mode == DEPTH_16) || (mode == DEPTH_32);
    end

    pu_stride #(.WIDTH_W(WIDTH_W)) u_stride (
        .mode  (mode),
        .width (panel_width),
        .bytes (row_bytes)
    );

    pu_word_buf u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .mode_ok   (mode_ok),
        .last_idx  (last_idx),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_word   (in_word),
        .buf_valid (out_valid),
        .buf_take  (out_ready),
        .buf_word  (cur_word),
        .buf_idx   (cur_idx)
    );

    pu_extract u_ext (
        .word        (cur_word),
        .mode        (mode),
        .swap_bytes  (swap_bytes),
        .swap_pixels (swap_pixels),
        .idx         (cur_idx),
        .pixel       (out_pixel)
    );

    assert_one_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (!active || !$stable(depth_mode) || !$stable(swap_bytes) ||
             !$stable(swap_pixels) || (out_valid && $stable(out_pixel))));

    assert_idle_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_enable && ctl_power) |-> (!in_ready && !out_valid));

    assert_zero_extend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && depth_mode == 3'd0) |-> (out_pixel[31:1] == '0));

    assert_no_reserved_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_mode[2:1] == 2'b11) |-> !out_valid);

endmodule

// File: tb/sim_pix_unpack.sv
module sim_pix_unpack;
    localparam int WW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_enable = 1'b1;
    logic          ctl_power = 1'b1;
    logic [2:0]    depth_mode = 3'd0;
    logic          swap_bytes = 1'b0;
    logic          swap_pixels = 1'b0;
    logic [WW-1:0] panel_width = '0;
    logic [WW+1:0] row_bytes;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_word = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [31:0]   out_pixel;
    logic          out_direct;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pix_unpack #(.WIDTH_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_power(ctl_power),
        .depth_mode(depth_mode), .swap_bytes(swap_bytes), .swap_pixels(swap_pixels),
        .panel_width(panel_width), .row_bytes(row_bytes),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pixel(out_pixel), .out_direct(out_direct)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // expected pixel k of word w, from R2..R4
    function automatic logic [31:0] exp_pix(input logic [31:0] w, input int mode,
                                            input bit sb, input bit sp, input int k);
        logic [31:0] s;
        int bpp, ppb, off, p;
        longint mask;
        s = sb ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        bpp = 1 << mode;
        if (bpp < 8) begin
            ppb = 8 / bpp;
            p = k % ppb;
            off = (k / ppb) * 8 + ((sp && !sb) ? (8 - bpp - p * bpp) : p * bpp);
        end else begin
            off = k * bpp;
        end
        mask = (64'd1 << bpp) - 1;
        return 32'((longint'(s) >> off) & mask);
    endfunction

    function automatic longint exp_rows(input int mode, input int w);
        case (mode)
            0: return w >> 3;
            1: return w >> 2;
            2: return w >> 1;
            3: return w;
            4: return w * 2;
            5: return w * 4;
            default: return 0;
        endcase
    endfunction

    // send one word and drain its pixels; called at a negedge
    task automatic run_word(input logic [31:0] w, input int mode,
                            input bit sb, input bit sp, input bit stall);
        int n, got, cyc;
        bit held;
        logic [31:0] heldpix;
        n = 32 >> mode;
        depth_mode = 3'(mode); swap_bytes = sb; swap_pixels = sp;
        out_ready = 1'b0;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        in_valid = 1'b1; in_word = w;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_valid && !in_ready, "R6", "busy after accept", {out_valid, in_ready}, 2'b10);
        got = 0; cyc = 0; held = 0; heldpix = '0;
        while (got < n) begin
            out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            #1;
            if (held) begin
                chk(out_valid && out_pixel == heldpix, "R7", "stalled pixel held",
                    out_pixel, heldpix);
                held = 0;
            end
            if (got > 0 && got < n) begin
                chk(!in_ready, "R6", "no accept mid-word", in_ready, 0);
            end
            if (out_valid && out_ready) begin
                chk(out_pixel == exp_pix(w, mode, sb, sp, got), "R2/R3/R4",
                    $sformatf("pixel m%0d sb%0d sp%0d k%0d", mode, sb, sp, got),
                    out_pixel, exp_pix(w, mode, sb, sp, got));
                chk(out_direct == (mode >= 4), "R10", "direct flag", out_direct, mode >= 4);
                got++;
            end else if (out_valid) begin
                held = 1; heldpix = out_pixel;
            end else begin
                chk(0, "R1", "pixel missing", 0, 1);
                got = n;
            end
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        #1;
        chk(in_ready && !out_valid, "R1", $sformatf("word done after %0d pixels", n),
            {out_valid, in_ready}, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] pat [4];
        pat[0] = 32'hA5C3_1E70; pat[1] = 32'h1B2D_F096;
        pat[2] = 32'h8E4F_0C31; pat[3] = 32'h7061_D2E9;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid && in_ready, "R11", "reset state", {out_valid, in_ready}, 2'b01);

        // R1..R4, R6, R7, R10: every depth, every ordering combination
        for (int m = 0; m < 6; m++) begin
            for (int c = 0; c < 4; c++) begin
                for (int j = 0; j < 2; j++) begin
                    @(negedge clk);
                    run_word(pat[(c + j + m) % 4], m, c[1], c[0], c[0] ^ j[0]);
                end
            end
        end

        // R5: row bytes over widths and codes
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 6; i++) begin
                int wv;
                wv = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 7 : (i == 3) ? 8 :
                     (i == 4) ? 640 : 4095;
                @(negedge clk);
                depth_mode = 3'(m); panel_width = WW'(wv);
                #1;
                chk(longint'(row_bytes) == exp_rows(m, wv), "R5",
                    $sformatf("row bytes m%0d w%0d", m, wv), row_bytes, exp_rows(m, wv));
            end
        end

        // R8: enable then power dropped mid-word, pixels resume in order
        for (int t = 0; t < 2; t++) begin
            int got;
            @(negedge clk);
            depth_mode = 3'd3; swap_bytes = 0; swap_pixels = 0; out_ready = 0;
            in_valid = 1'b1; in_word = 32'h4433_2211;
            @(negedge clk);
            in_valid = 1'b0;
            if (t == 0) ctl_enable = 1'b0; else ctl_power = 1'b0;
            out_ready = 1'b1;
            repeat (3) begin
                #1;
                chk(!out_valid && !in_ready, "R8", "inactive outputs", {out_valid, in_ready}, 0);
                @(negedge clk);
            end
            ctl_enable = 1'b1; ctl_power = 1'b1;
            got = 0;
            while (got < 4) begin
                #1;
                chk(out_valid && out_pixel == 32'(8'h11 * (got + 1)), "R8", "resumed pixel",
                    out_pixel, 8'h11 * (got + 1));
                got++;
                @(negedge clk);
            end
            out_ready = 1'b0;
        end

        // R9: reserved codes accept and drop words
        for (int m = 6; m < 8; m++) begin
            @(negedge clk);
            depth_mode = 3'(m); out_ready = 1'b1;
            #1;
            chk(in_ready, "R9", "reserved accepts", in_ready, 1);
            in_valid = 1'b1; in_word = 32'hFFFF_FFFF;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (3) begin
                #1;
                chk(!out_valid && in_ready, "R9", "reserved emits nothing",
                    {out_valid, in_ready}, 2'b01);
                @(negedge clk);
            end
        end
        out_ready = 1'b0;

        // back to a valid mode after reserved: nothing stale appears
        depth_mode = 3'd5;
        #1;
        chk(!out_valid, "R9", "no stale pixel after reserved", out_valid, 0);
        @(negedge clk);
        run_word(32'hDEAD_BEEF, 5, 1'b1, 1'b1, 1'b1);

        finish_run();
    end

endmodule